// File: doc/BRIEF.md
# Bus-Master DMA Register Block for a Two-Channel Disk Controller

This block holds the per-channel bus-master registers of a disk controller: a command byte that starts and stops a transfer and chooses its direction, a status byte that reports activity, error, interrupt and drive DMA capability, and a 32-bit pointer to the transfer's descriptor table. Host software reaches the registers through a byte-addressed write port with a size code and a combinational read port. A master enable from the PCI command register gates all register writes.

Toward the DMA engine the block emits a one-cycle start request whenever software raises a channel's run bit, and a one-cycle abort request when software lowers it. The descriptor-table pointer is presented continuously. The engine reports back with a completion pulse and a fault pulse per channel. Completion stops the channel and raises its interrupt. Each channel drives an interrupt line that mirrors its interrupt status bit.

Top module: `bmide_regs`

## Requirements
- R1: After a synchronous reset every channel reads command 0x00, status 0x60 (both capability bits set), pointer 0x00000000; all request pulses, the size error and the interrupts are low.
- R2: While `bm_en` is low, host writes change no register, raise no request pulse and do not raise `size_err`.
- R3: Size codes are 0 byte, 1 halfword, 2 word, 3 invalid. Command and status accept only byte writes and the pointer accepts only word writes. Any other size leaves the register unchanged and raises `size_err` for one cycle, in the cycle after the write.
- R4: Command bit 3 (direction) takes the written value only while command bit 0 (run) is 0. While run is 1, a write leaves direction unchanged.
- R5: A command write that takes run from 0 to 1 sets status bit 0 (active) and pulses that channel's `dma_start` for one cycle, in the cycle after the write. During that pulse `dma_ptr` shows the channel's pointer.
- R6: A command write that takes run from 1 to 0 clears active and pulses that channel's `dma_abort` for one cycle, in the cycle after the write.
- R7: In status, bit 0 ignores host writes. Bits 1 (error) and 2 (interrupt) clear only where a 1 is written. Bits 6:5 (capability) take the written value. Bits 3, 4 and 7 and command bits 1, 2 and 4 to 7 read 0.
- R8: A word write to the pointer stores the data with bits 1:0 forced to 0.
- R9: A `dma_done` pulse clears run and active and sets interrupt. It overrides a same-cycle command write, which then raises no start or abort request but still updates direction under R4. It also overrides a same-cycle write of 1 to interrupt.
- R10: `irq[c]` equals status bit 2 of channel c in every cycle.
- R11: A `dma_fault` pulse sets status bit 1. A same-cycle write of 1 to that bit does not clear it.
- R12: Address bit 3 selects the channel. Offsets 0, 2 and 4 hold command, status and pointer. Writes to any other offset change nothing and raise no error. Reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bm_en | input | 1 | Bus-master enable from the PCI command register |
| wr_valid | input | 1 | Host write strobe |
| wr_addr | input | 4 | Write byte address |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data, byte data in bits 7:0 |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 32 | Read data, combinational |
| size_err | output | 1 | Write of a wrong size, one cycle |
| dma_done | input | 2 | Per-channel transfer-complete pulse |
| dma_fault | input | 2 | Per-channel transfer-error pulse |
| dma_start | output | 2 | Per-channel start request |
| dma_abort | output | 2 | Per-channel abort request |
| dma_ptr | output | 64 | Descriptor pointers, channel c at bits 32c+31:32c |
| irq | output | 2 | Per-channel interrupt |

## Verification
Every byte value is written to each channel's command register in sequence. The sweep therefore reaches each run/direction transition from both run states, which separates the direction lock from the start and abort edges. Every byte value is also written to status after completion and fault pulses have raised the interrupt and error bits, so write-one-to-clear is checked against plain writes and the read-only active bit. All four size codes are applied at every register offset with the master enable on and off, which distinguishes wrong-size rejection from disabled writes and from unmapped offsets. Completion and fault pulses that coincide with host writes show which side wins.

// File: rtl/bmide_pkg.sv
package bmide_pkg;

    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;

    // per-channel byte offsets
    localparam logic [2:0] OFF_CMD = 3'd0;
    localparam logic [2:0] OFF_STS = 3'd2;
    localparam logic [2:0] OFF_PTR = 3'd4;

    // command bits
    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;

    // status bits
    localparam int STS_ACT  = 0;
    localparam int STS_ERR  = 1;
    localparam int STS_INT  = 2;
    localparam int STS_CAP0 = 5;
    localparam int STS_CAP1 = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic             go;
        logic             dir;
        logic             act;
        logic             err;
        logic             intr;
        logic [1:0]       cap;
        logic [REG_W-3:0] ptr_hi;
    } chan_regs_t;

    function automatic chan_regs_t reset_image();
        chan_regs_t r;
        r     = '0;
        r.cap = 2'b11;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] cmd_image(chan_regs_t r);
        logic [BYTE_W-1:0] b;
        b          = '0;
        b[CMD_GO]  = r.go;
        b[CMD_DIR] = r.dir;
        return b;
    endfunction

    function automatic logic [BYTE_W-1:0] sts_image(chan_regs_t r);
        logic [BYTE_W-1:0] b;
        b           = '0;
        b[STS_ACT]  = r.act;
        b[STS_ERR]  = r.err;
        b[STS_INT]  = r.intr;
        b[STS_CAP0] = r.cap[0];
        b[STS_CAP1] = r.cap[1];
        return b;
    endfunction

    function automatic logic [REG_W-1:0] ptr_image(chan_regs_t r);
        return {r.ptr_hi, 2'b00};
    endfunction

    // required size for a mapped offset
    function automatic logic size_fits(logic [2:0] off, logic [1:0] sz);
        case (off)
            OFF_CMD, OFF_STS: return sz == SZ_BYTE;
            OFF_PTR:          return sz == SZ_WORD;
            default:          return 1'b1;
        endcase
    endfunction

    function automatic logic is_mapped(logic [2:0] off);
        return (off == OFF_CMD) || (off == OFF_STS) || (off == OFF_PTR);
    endfunction

endpackage

// File: rtl/bmide_decode.sv
module bmide_decode
    import bmide_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    parameter int ADDR_W = 4
) (
    input  logic              bm_en,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    output logic [NUM_CH-1:0] cmd_we,
    output logic [NUM_CH-1:0] sts_we,
    output logic [NUM_CH-1:0] ptr_we,
    output logic              size_bad
);

    logic [CH_W-1:0] ch_idx;
    logic [2:0]      off;
    logic            live;
    logic            fits;

    assign ch_idx = wr_addr[ADDR_W-1:3];
    assign off    = wr_addr[2:0];
    assign live   = wr_valid && bm_en && (int'(ch_idx) < NUM_CH);
    assign fits   = size_fits(off, wr_size);

    assign size_bad = live && is_mapped(off) && !fits;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        logic hit;
        assign hit       = live && fits && (ch_idx == CH_W'(i));
        assign cmd_we[i] = hit && (off == OFF_CMD);
        assign sts_we[i] = hit && (off == OFF_STS);
        assign ptr_we[i] = hit && (off == OFF_PTR);
    end

endmodule

// File: rtl/bmide_chan.sv
module bmide_chan
    import bmide_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic             sts_we,
    input  logic             ptr_we,
    input  logic [REG_W-1:0] wr_data,
    input  logic             done,
    input  logic             fault,
    output chan_regs_t       regs,
    output logic             start_pulse,
    output logic             abort_pulse
);

    chan_regs_t nxt;
    logic       go_up;
    logic       go_dn;

    always_comb begin
        go_up = cmd_we && !regs.go && wr_data[CMD_GO] && !done;
        go_dn = cmd_we && regs.go && !wr_data[CMD_GO] && !done;
        nxt   = regs;

        if (cmd_we) begin
            nxt.go = wr_data[CMD_GO];
            if (!regs.go) nxt.dir = wr_data[CMD_DIR];
        end
        if (go_up) nxt.act = 1'b1;
        if (go_dn) nxt.act = 1'b0;

        if (sts_we) begin
            if (wr_data[STS_ERR]) nxt.err  = 1'b0;
            if (wr_data[STS_INT]) nxt.intr = 1'b0;
            nxt.cap = wr_data[STS_CAP1:STS_CAP0];
        end
        if (fault) nxt.err = 1'b1;

        if (done) begin
            nxt.go   = 1'b0;
            nxt.act  = 1'b0;
            nxt.intr = 1'b1;
        end

        if (ptr_we) nxt.ptr_hi = wr_data[REG_W-1:2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs        <= reset_image();
            start_pulse <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            regs        <= nxt;
            start_pulse <= go_up;
            abort_pulse <= go_dn;
        end
    end

    p_dir_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && regs.go && !done) |=> (regs.dir == $past(regs.dir)));

    p_start_active_r5: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (regs.act && regs.go));

    p_abort_idle_r6: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> (!regs.act && !regs.go));

    p_pulse_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(start_pulse && abort_pulse));

    p_done_wins_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!regs.go && !regs.act && regs.intr && !start_pulse && !abort_pulse));

    p_fault_sets_r11: assert property (@(posedge clk) disable iff (rst)
        fault |=> regs.err);

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !(cmd_we || sts_we || ptr_we || done || fault)
        |=> ($stable(regs) && !start_pulse && !abort_pulse));

endmodule

// File: rtl/bmide_rdmux.sv
module bmide_rdmux
    import bmide_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    parameter int ADDR_W = 4
) (
    input  chan_regs_t [NUM_CH-1:0] regs,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [REG_W-1:0]        rd_data
);

    logic [CH_W-1:0] ch_idx;
    logic [2:0]      off;

    assign ch_idx = rd_addr[ADDR_W-1:3];
    assign off    = rd_addr[2:0];

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == CH_W'(i)) begin
                case (off)
                    OFF_CMD: rd_data = REG_W'(cmd_image(regs[i]));
                    OFF_STS: rd_data = REG_W'(sts_image(regs[i]));
                    OFF_PTR: rd_data = ptr_image(regs[i]);
                    default: rd_data = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/bmide_regs.sv
module bmide_regs
    import bmide_pkg::*;
#(
    parameter  int NUM_CH = 2,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bm_en,
    input  logic                    wr_valid,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [1:0]              wr_size,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [REG_W-1:0]        rd_data,
    output logic                    size_err,
    input  logic [NUM_CH-1:0]       dma_done,
    input  logic [NUM_CH-1:0]       dma_fault,
    output logic [NUM_CH-1:0]       dma_start,
    output logic [NUM_CH-1:0]       dma_abort,
    output logic [NUM_CH*REG_W-1:0] dma_ptr,
    output logic [NUM_CH-1:0]       irq
);

    logic [NUM_CH-1:0]       cmd_we;
    logic [NUM_CH-1:0]       sts_we;
    logic [NUM_CH-1:0]       ptr_we;
    logic                    size_bad;
    chan_regs_t [NUM_CH-1:0] st;

    bmide_decode #(
        .NUM_CH(NUM_CH),
        .CH_W  (CH_W),
        .ADDR_W(ADDR_W)
    ) u_decode (
        .bm_en   (bm_en),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_size (wr_size),
        .cmd_we  (cmd_we),
        .sts_we  (sts_we),
        .ptr_we  (ptr_we),
        .size_bad(size_bad)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        bmide_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .cmd_we     (cmd_we[i]),
            .sts_we     (sts_we[i]),
            .ptr_we     (ptr_we[i]),
            .wr_data    (wr_data),
            .done       (dma_done[i]),
            .fault      (dma_fault[i]),
            .regs       (st[i]),
            .start_pulse(dma_start[i]),
            .abort_pulse(dma_abort[i])
        );
        assign dma_ptr[i*REG_W +: REG_W] = ptr_image(st[i]);
        assign irq[i]                    = st[i].intr;
    end

    bmide_rdmux #(
        .NUM_CH(NUM_CH),
        .CH_W  (CH_W),
        .ADDR_W(ADDR_W)
    ) u_rdmux (
        .regs   (st),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) size_err <= 1'b0;
        else     size_err <= size_bad;
    end

    p_no_err_disabled_r2: assert property (@(posedge clk) disable iff (rst)
        !bm_en |=> !size_err);

    p_frozen_disabled_r2: assert property (@(posedge clk) disable iff (rst)
        (!bm_en && dma_done == '0 && dma_fault == '0) |=> $stable(st));

    p_bad_size_no_update_r3: assert property (@(posedge clk) disable iff (rst)
        (size_err && $past(dma_done) == '0 && $past(dma_fault) == '0) |-> $stable(st));

    p_one_target_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_we, sts_we, ptr_we}));

endmodule

// File: tb/bmide_regs_tb_top.sv
module bmide_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bm_en = 1'b0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        size_err;
    logic [1:0]  dma_done = '0;
    logic [1:0]  dma_fault = '0;
    logic [1:0]  dma_start;
    logic [1:0]  dma_abort;
    logic [63:0] dma_ptr;
    logic [1:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  m_cmd [2];
    logic [7:0]  m_sts [2];
    logic [31:0] m_ptr [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    bmide_regs #(.NUM_CH(2)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .bm_en    (bm_en),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_size  (wr_size),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .size_err (size_err),
        .dma_done (dma_done),
        .dma_fault(dma_fault),
        .dma_start(dma_start),
        .dma_abort(dma_abort),
        .dma_ptr  (dma_ptr),
        .irq      (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // reads every register of both channels and the side outputs
    task automatic check_all(input string tag);
        for (int c = 0; c < 2; c++) begin
            rd_addr = {c[0], 3'd0}; #1; chk({tag, " cmd"}, rd_data, {24'h0, m_cmd[c]});
            rd_addr = {c[0], 3'd2}; #1; chk({tag, " sts"}, rd_data, {24'h0, m_sts[c]});
            rd_addr = {c[0], 3'd4}; #1; chk({tag, " ptr"}, rd_data, m_ptr[c]);
            rd_addr = {c[0], 3'd1}; #1; chk("R12 unmapped read", rd_data, 32'h0);
            rd_addr = {c[0], 3'd6}; #1; chk("R12 unmapped read", rd_data, 32'h0);
            chk("R10 irq", 32'(irq[c]), 32'(m_sts[c][2]));
            chk("R5 dma_ptr", dma_ptr[c*32 +: 32], m_ptr[c]);
        end
    endtask

    // one clock of stimulus, checked against the requirement model
    task automatic step(input logic w, input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input logic [1:0] dn, input logic [1:0] ft,
                        input string tag);
        logic [1:0] es;
        logic [1:0] eab;
        logic       eerr;
        es = '0; eab = '0; eerr = 1'b0;
        for (int c = 0; c < 2; c++) begin
            logic hit, cw, sw, pw, go, act;
            hit = w && bm_en && (a[3] == c[0]);
            cw  = hit && a[2:0] == 3'd0 && sz == 2'd0;
            sw  = hit && a[2:0] == 3'd2 && sz == 2'd0;
            pw  = hit && a[2:0] == 3'd4 && sz == 2'd2;
            if (hit && (((a[2:0] == 3'd0 || a[2:0] == 3'd2) && sz != 2'd0) ||
                        (a[2:0] == 3'd4 && sz != 2'd2)))
                eerr = 1'b1;
            go  = m_cmd[c][0];
            act = m_sts[c][0];
            es[c]  = cw && !go && d[0] && !dn[c];
            eab[c] = cw && go && !d[0] && !dn[c];
            if (cw) begin
                if (!go) m_cmd[c][3] = d[3];
                m_cmd[c][0] = d[0];
            end
            if (dn[c]) m_cmd[c][0] = 1'b0;
            if (es[c])  act = 1'b1;
            if (eab[c]) act = 1'b0;
            if (dn[c])  act = 1'b0;
            m_sts[c][0] = act;
            if (sw) begin
                if (d[1]) m_sts[c][1] = 1'b0;
                if (d[2]) m_sts[c][2] = 1'b0;
                m_sts[c][6:5] = d[6:5];
            end
            if (ft[c]) m_sts[c][1] = 1'b1;
            if (dn[c]) m_sts[c][2] = 1'b1;
            if (pw) m_ptr[c] = d & ~32'h3;
        end
        wr_valid  = w;
        wr_addr   = a;
        wr_size   = sz;
        wr_data   = d;
        dma_done  = dn;
        dma_fault = ft;
        @(posedge clk);
        @(negedge clk);
        wr_valid  = 1'b0;
        dma_done  = '0;
        dma_fault = '0;
        chk({tag, " start"}, 32'(dma_start), 32'(es));
        chk({tag, " abort"}, 32'(dma_abort), 32'(eab));
        chk({tag, " size_err"}, 32'(size_err), 32'(eerr));
        check_all(tag);
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_cmd[c] = 8'h00;
            m_sts[c] = 8'h60;
            m_ptr[c] = 32'h0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1");
        chk("R1 start", 32'(dma_start), 32'h0);
        chk("R1 abort", 32'(dma_abort), 32'h0);
        chk("R1 size_err", 32'(size_err), 32'h0);

        bm_en = 1'b1;
        step(1'b1, 4'h4, 2'd2, 32'hFFFF_FFFF, 2'b00, 2'b00, "R8");
        step(1'b1, 4'hC, 2'd2, 32'h1234_5677, 2'b00, 2'b00, "R8");

        for (int c = 0; c < 2; c++)
            for (int o = 0; o < 3; o++)
                for (int s = 0; s < 4; s++)
                    step(1'b1, {c[0], 3'(2 * o)}, 2'(s), 32'hC3A5_5A08 ^ 32'(s << 12),
                         2'b00, 2'b00, "R3");

        bm_en = 1'b0;
        for (int a = 0; a < 16; a++)
            for (int s = 0; s < 4; s++)
                step(1'b1, 4'(a), 2'(s), 32'hFFFF_FFFF, 2'b00, 2'b00, "R2");
        bm_en = 1'b1;

        for (int c = 0; c < 2; c++)
            for (int v = 0; v < 256; v++)
                step(1'b1, {c[0], 3'd0}, 2'd0, 32'(v), 2'b00, 2'b00, "R4/R5/R6");

        for (int c = 0; c < 2; c++)
            for (int v = 0; v < 256; v++) begin
                logic [1:0] sel;
                sel = 2'b01 << c;
                step(1'b0, 4'h0, 2'd0, 32'h0, v[0] ? sel : 2'b00, v[1] ? sel : 2'b00, "R9/R11");
                step(1'b1, {c[0], 3'd2}, 2'd0, 32'(v), 2'b00, 2'b00, "R7/R10");
            end

        step(1'b1, 4'h0, 2'd0, 32'h0, 2'b00, 2'b00, "R9");
        step(1'b1, 4'h0, 2'd0, 32'h9, 2'b01, 2'b00, "R9");
        step(1'b1, 4'h0, 2'd0, 32'h1, 2'b00, 2'b00, "R5");
        step(1'b1, 4'h0, 2'd0, 32'h0, 2'b01, 2'b00, "R9");
        step(1'b1, 4'h2, 2'd0, 32'h4, 2'b01, 2'b00, "R9");
        step(1'b1, 4'hA, 2'd0, 32'h2, 2'b00, 2'b10, "R11");
        step(1'b1, 4'hA, 2'd0, 32'h6, 2'b00, 2'b00, "R7");
        step(1'b1, 4'h8, 2'd0, 32'h1, 2'b00, 2'b00, "R5");
        step(1'b1, 4'h8, 2'd0, 32'h1, 2'b10, 2'b00, "R9");

        for (int c = 0; c < 2; c++)
            for (int o = 0; o < 8; o++)
                if (o != 0 && o != 2 && o != 4)
                    for (int s = 0; s < 4; s++)
                        step(1'b1, {c[0], 3'(o)}, 2'(s), 32'hFFFF_FFFF, 2'b00, 2'b00, "R12");

        summary();
        $finish;
    end

endmodule